// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the instruction-fetch stream and the data-access stream of a core and compares every request against up to four programmable breakpoint slots. Each slot holds one linear address. A shared watch-control register gives each slot a local and a global enable, a 2-bit condition code that selects what kind of access the slot reacts to, and a 2-bit length code that sets how many bytes the slot covers. When an enabled slot matches, its bit in a sticky hit-status register is set, and a one-cycle debug request is sent to the exception logic.

Software programs the slots through a small register port with a write strobe and a combinational read. A task-switch pulse from the core drops all local enables and keeps the global ones, so a breakpoint can be limited to one task or kept across task switches. Addresses reaching the block are already linear. Translation and exception handling are done elsewhere.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset all slot addresses, the watch-control register and the hit-status register read zero, and `dbg_req` is low.
- R2: Register offsets 0 to 3 are the slot addresses, offset 4 is hit status (bits 0 to 3, upper bits read zero), offset 5 is watch control, and offsets 6 and 7 read zero and ignore writes. Watch-control bits 8 to 15 ignore writes and read zero.
- R3: Condition 00 (execute) matches only a valid fetch whose address equals the slot address exactly, whatever the length code says. Data accesses never match it.
- R4: Condition 01 matches only data writes whose byte range overlaps the slot range.
- R5: Condition 11 matches data reads and data writes whose byte range overlaps the slot range.
- R6: Condition 10 is reserved and never matches, whatever access arrives.
- R7: Length code 00, 01, 11 and 10 cover 1, 2, 4 and 8 bytes. The slot address is aligned down to that size. A data access of `data_size` 0, 1, 2 or 3 covers 1, 2, 4 or 8 bytes from `data_addr`.
- R8: Slot n is enabled when control bit 2n (local) or bit 2n+1 (global) is set. A disabled slot never hits.
- R9: A `task_sw` pulse clears every even (local) enable bit and leaves the odd (global) bits unchanged. If a control write arrives in the same cycle, the written value is taken first and its local bits are then cleared.
- R10: Status bit n is set on the clock edge that ends a cycle in which slot n hits. Status bits are sticky and change otherwise only through a software write. A hit wins over a software write to the status register in the same cycle.
- R11: `dbg_req` is high for exactly the cycle after a cycle with at least one hit, and status is already set in that cycle. Several slots hitting together set several status bits at once.
- R12: Condition field n sits at control bits 16+4n to 17+4n and length field n sits at bits 18+4n to 19+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| task_sw | input | 1 | Task-switch pulse, clears local enables |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | ADDR_W | Fetch linear address |
| data_valid | input | 1 | Data access present |
| data_addr | input | ADDR_W | Data access linear start address |
| data_size | input | 2 | Access size, log2 of bytes |
| data_write | input | 1 | 1 for write, 0 for read |
| dbg_req | output | 1 | One-cycle debug-exception request |

## Verification
The assertions assume that `task_sw` and the register strobe are synchronous single-cycle controls and that the request inputs are valid only when their valid bit is high. They also assume that a data access does not wrap past the top of the address space. The bench drives every input on the falling edge and holds each request for exactly one cycle. It keeps all addresses well below the top of the space, so overlap is never tested across a wrap. Concurrent events (task switch with a control write, hit with a status write, fetch and data hits together) are created on purpose, so that the priority rules are exercised with the assertions active.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

   localparam int unsigned MAX_SLOTS    = 4;
   localparam int unsigned FIELD_BASE   = 16;
   localparam int unsigned FIELD_STRIDE = 4;
   localparam int unsigned REG_STATUS   = 4;
   localparam int unsigned REG_CTRL     = 5;

   typedef enum logic [1:0] {
      COND_EXEC  = 2'b00,
      COND_WRITE = 2'b01,
      COND_IO    = 2'b10,
      COND_RDWR  = 2'b11
   } cond_e;

   // length code sits above condition code inside a 4-bit slot field
   typedef struct packed {
      logic [1:0] len;
      cond_e      cond;
   } slot_field_t;

   function automatic logic [3:0] span_bytes(input logic [1:0] code);
      case (code)
         2'b00:   span_bytes = 4'd1;
         2'b01:   span_bytes = 4'd2;
         2'b11:   span_bytes = 4'd4;
         default: span_bytes = 4'd8;
      endcase
   endfunction

   function automatic logic [3:0] access_bytes(input logic [1:0] sz);
      access_bytes = 4'd1 << sz;
   endfunction

   function automatic logic [2*MAX_SLOTS-1:0] local_mask();
      logic [2*MAX_SLOTS-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_SLOTS; i++) m[2*i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/bkpt_slot_cmp.sv
`timescale 1ns/1ps
module bkpt_slot_cmp
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              enable,
   input  slot_field_t       field,
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [1:0]        data_size,
   input  logic              data_write,
   output logic              hit
);

   localparam int unsigned EXT_W = ADDR_W + 1;

   logic [3:0]        slot_span;
   logic [3:0]        acc_span;
   logic [ADDR_W-1:0] align_mask;
   logic [EXT_W-1:0]  slot_lo;
   logic [EXT_W-1:0]  slot_hi;
   logic [EXT_W-1:0]  acc_lo;
   logic [EXT_W-1:0]  acc_hi;
   logic              overlap;
   logic              exec_match;
   logic              cond_match;

   always_comb begin
      slot_span  = span_bytes(field.len);
      acc_span   = access_bytes(data_size);
      align_mask = ~(ADDR_W'(slot_span) - ADDR_W'(1));
      slot_lo    = {1'b0, slot_addr & align_mask};
      slot_hi    = slot_lo + EXT_W'(slot_span) - EXT_W'(1);
      acc_lo     = {1'b0, data_addr};
      acc_hi     = acc_lo + EXT_W'(acc_span) - EXT_W'(1);
      overlap    = (acc_lo <= slot_hi) && (slot_lo <= acc_hi);
      exec_match = fetch_valid && (fetch_addr == slot_addr);
   end

   always_comb begin
      case (field.cond)
         COND_EXEC:  cond_match = exec_match;
         COND_WRITE: cond_match = data_valid && data_write && overlap;
         COND_RDWR:  cond_match = data_valid && overlap;
         default:    cond_match = 1'b0;
      endcase
   end

   assign hit = enable && cond_match;

endmodule

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned REG_AW    = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 reg_we,
   input  logic [REG_AW-1:0]                    reg_addr,
   input  logic [DATA_W-1:0]                    reg_wdata,
   output logic [DATA_W-1:0]                    reg_rdata,
   input  logic                                 task_sw,
   input  logic [NUM_SLOTS-1:0]                 slot_hit,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]     slot_addr,
   output logic [2*NUM_SLOTS-1:0]               ctrl_en,
   output slot_field_t [NUM_SLOTS-1:0]          ctrl_field,
   output logic [NUM_SLOTS-1:0]                 hit_status
);

   localparam int unsigned EN_W = 2 * NUM_SLOTS;
   localparam logic [EN_W-1:0] LOCAL_BITS = local_mask()[EN_W-1:0];

   logic wr_status;
   logic wr_ctrl;

   assign wr_status = reg_we && (reg_addr == REG_AW'(REG_STATUS));
   assign wr_ctrl   = reg_we && (reg_addr == REG_AW'(REG_CTRL));

   // slot address registers
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_addr[g] <= '0;
         else if (reg_we && (reg_addr == REG_AW'(g)))
            slot_addr[g] <= reg_wdata[ADDR_W-1:0];
      end
   end

   // enable bits: software write first, then task switch drops locals
   logic [EN_W-1:0] en_nxt;
   always_comb begin
      en_nxt = wr_ctrl ? reg_wdata[EN_W-1:0] : ctrl_en;
      if (task_sw) en_nxt = en_nxt & ~LOCAL_BITS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_en <= '0;
      else        ctrl_en <= en_nxt;
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_field[g] <= '{len: 2'b00, cond: COND_EXEC};
         else if (wr_ctrl)
            ctrl_field[g] <= slot_field_t'(reg_wdata[FIELD_BASE + FIELD_STRIDE*g +: FIELD_STRIDE]);
      end
   end

   // sticky status, hardware hits override software
   logic [NUM_SLOTS-1:0] status_nxt;
   always_comb begin
      status_nxt = wr_status ? reg_wdata[NUM_SLOTS-1:0] : hit_status;
      status_nxt = status_nxt | slot_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_status <= '0;
      else        hit_status <= status_nxt;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (reg_addr == REG_AW'(i)) reg_rdata[ADDR_W-1:0] = slot_addr[i];
      end
      if (reg_addr == REG_AW'(REG_STATUS)) reg_rdata[NUM_SLOTS-1:0] = hit_status;
      if (reg_addr == REG_AW'(REG_CTRL)) begin
         reg_rdata[EN_W-1:0] = ctrl_en;
         for (int i = 0; i < NUM_SLOTS; i++)
            reg_rdata[FIELD_BASE + FIELD_STRIDE*i +: FIELD_STRIDE] = ctrl_field[i];
      end
   end

endmodule

// File: rtl/bkpt_match_unit.sv
`timescale 1ns/1ps
module bkpt_match_unit
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned REG_AW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              task_sw,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [1:0]        data_size,
   input  logic              data_write,
   output logic              dbg_req
);

   localparam int unsigned EN_W = 2 * NUM_SLOTS;

   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must lie between 1 and 4");
   end
   if (DATA_W < FIELD_BASE + FIELD_STRIDE * MAX_SLOTS || DATA_W < ADDR_W) begin : g_bad_data
      $error("DATA_W must hold the control layout and a full address");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover an 8-byte span");
   end
   if (REG_AW < 3) begin : g_bad_regaw
      $error("REG_AW must decode offsets 0 to 5");
   end

   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
   logic [EN_W-1:0]                  ctrl_en;
   slot_field_t [NUM_SLOTS-1:0]      ctrl_field;
   logic [NUM_SLOTS-1:0]             hit_status;
   logic [NUM_SLOTS-1:0]             slot_hit;

   bkpt_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_SLOTS(NUM_SLOTS),
      .REG_AW   (REG_AW)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .task_sw   (task_sw),
      .slot_hit  (slot_hit),
      .slot_addr (slot_addr),
      .ctrl_en   (ctrl_en),
      .ctrl_field(ctrl_field),
      .hit_status(hit_status)
   );

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      bkpt_slot_cmp #(
         .ADDR_W(ADDR_W)
      ) i_cmp (
         .enable     (ctrl_en[2*g] | ctrl_en[2*g+1]),
         .field      (ctrl_field[g]),
         .slot_addr  (slot_addr[g]),
         .fetch_valid(fetch_valid),
         .fetch_addr (fetch_addr),
         .data_valid (data_valid),
         .data_addr  (data_addr),
         .data_size  (data_size),
         .data_write (data_write),
         .hit        (slot_hit[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbg_req <= 1'b0;
      else        dbg_req <= |slot_hit;
   end

endmodule

// File: rtl/bkpt_match_chk.sv
`timescale 1ns/1ps
module bkpt_match_chk
   import bkpt_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned REG_AW    = 3,
   parameter int unsigned DATA_W    = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_we,
   input logic [REG_AW-1:0]             reg_addr,
   input logic                          task_sw,
   input logic                          dbg_req,
   input logic [NUM_SLOTS-1:0]          slot_hit,
   input logic [NUM_SLOTS-1:0]          hit_status,
   input logic [2*NUM_SLOTS-1:0]        ctrl_en,
   input slot_field_t [NUM_SLOTS-1:0]   ctrl_field
);

   localparam int unsigned EN_W = 2 * NUM_SLOTS;
   localparam logic [EN_W-1:0] LMASK = local_mask()[EN_W-1:0];

   logic [NUM_SLOTS-1:0] slot_on;
   logic [NUM_SLOTS-1:0] io_sel;
   logic                 status_wr;
   logic                 ctrl_wr;

   always_comb begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
         slot_on[i] = ctrl_en[2*i] || ctrl_en[2*i+1];
         io_sel[i]  = (ctrl_field[i].cond == COND_IO);
      end
   end

   assign status_wr = reg_we && (reg_addr == REG_AW'(REG_STATUS));
   assign ctrl_wr   = reg_we && (reg_addr == REG_AW'(REG_CTRL));

   p_io_never_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit & io_sel) == '0);

   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit & ~slot_on) == '0);

   p_task_sw_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
      task_sw |=> ((ctrl_en & LMASK) == '0));

   p_task_sw_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (task_sw && !ctrl_wr) |=> ((ctrl_en & ~LMASK) == $past(ctrl_en & ~LMASK)));

   p_hit_sets_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_hit) |=> ((hit_status & $past(slot_hit)) == $past(slot_hit)));

   p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_wr && !(|slot_hit)) |=> $stable(hit_status));

   p_req_after_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_hit) |=> dbg_req);

   p_no_req_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(|slot_hit) |=> !dbg_req);

   p_req_sees_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> (|hit_status));

endmodule

bind bkpt_match_unit bkpt_match_chk #(
   .NUM_SLOTS(NUM_SLOTS),
   .REG_AW   (REG_AW),
   .DATA_W   (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .task_sw   (task_sw),
   .dbg_req   (dbg_req),
   .slot_hit  (slot_hit),
   .hit_status(hit_status),
   .ctrl_en   (ctrl_en),
   .ctrl_field(ctrl_field)
);

// File: tb/test_bkpt_match_unit.sv
`timescale 1ns/1ps
module test_bkpt_match_unit;

   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          task_sw = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          data_valid = 1'b0;
   logic [AW-1:0] data_addr = '0;
   logic [1:0]    data_size = '0;
   logic          data_write = 1'b0;
   logic          dbg_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bkpt_match_unit i_bkpt_match_unit (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .task_sw(task_sw),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .data_valid(data_valid),
      .data_addr(data_addr), .data_size(data_size), .data_write(data_write),
      .dbg_req(dbg_req)
   );

   typedef struct packed {
      logic [7:0]  en;
      logic [7:0]  cond;  // slot n at [2n+1:2n]
      logic [7:0]  len;   // slot n at [2n+1:2n]
      logic        fv;
      logic [31:0] fa;
      logic        dv;
      logic [31:0] da;
      logic [1:0]  ds;
      logic        dw;
      logic [3:0]  exp;
   } vec_t;

   // slot addresses: 0x1000, 0x2003, 0x3005, 0x400C
   localparam int NVEC = 20;
   localparam vec_t VEC [NVEC] = '{
      '{8'h01, 8'h00, 8'h00, 1'b1, 32'h1000, 1'b0, 32'h0,    2'd0, 1'b0, 4'b0001}, // R3 exact
      '{8'h01, 8'h00, 8'h00, 1'b1, 32'h1001, 1'b0, 32'h0,    2'd0, 1'b0, 4'b0000}, // R3 miss
      '{8'h02, 8'h00, 8'h03, 1'b1, 32'h1002, 1'b0, 32'h0,    2'd0, 1'b0, 4'b0000}, // R3 len ignored
      '{8'h02, 8'h00, 8'h00, 1'b0, 32'h0,    1'b1, 32'h1000, 2'd0, 1'b1, 4'b0000}, // R3 data no
      '{8'h04, 8'h04, 8'h00, 1'b0, 32'h0,    1'b1, 32'h2003, 2'd0, 1'b1, 4'b0010}, // R4 write
      '{8'h04, 8'h04, 8'h00, 1'b0, 32'h0,    1'b1, 32'h2003, 2'd0, 1'b0, 4'b0000}, // R4 read no
      '{8'h08, 8'h0C, 8'h00, 1'b0, 32'h0,    1'b1, 32'h2003, 2'd0, 1'b0, 4'b0010}, // R5 read
      '{8'h08, 8'h0C, 8'h04, 1'b0, 32'h0,    1'b1, 32'h2002, 2'd0, 1'b0, 4'b0010}, // R7 2B align
      '{8'h08, 8'h0C, 8'h04, 1'b0, 32'h0,    1'b1, 32'h2001, 2'd0, 1'b0, 4'b0000}, // R7 below
      '{8'h08, 8'h0C, 8'h04, 1'b0, 32'h0,    1'b1, 32'h2000, 2'd2, 1'b0, 4'b0010}, // R7 4B access
      '{8'h10, 8'h30, 8'h20, 1'b0, 32'h0,    1'b1, 32'h3007, 2'd0, 1'b1, 4'b0100}, // R7 8B top
      '{8'h10, 8'h30, 8'h20, 1'b0, 32'h0,    1'b1, 32'h3008, 2'd0, 1'b0, 4'b0000}, // R7 8B above
      '{8'h10, 8'h30, 8'h30, 1'b0, 32'h0,    1'b1, 32'h3002, 2'd2, 1'b0, 4'b0100}, // R7 4B partial
      '{8'h10, 8'h30, 8'h30, 1'b0, 32'h0,    1'b1, 32'h3000, 2'd2, 1'b0, 4'b0000}, // R7 4B below
      '{8'hC0, 8'h80, 8'h00, 1'b0, 32'h0,    1'b1, 32'h400C, 2'd0, 1'b1, 4'b0000}, // R6 data
      '{8'hC0, 8'h80, 8'h00, 1'b1, 32'h400C, 1'b0, 32'h0,    2'd0, 1'b0, 4'b0000}, // R6 fetch
      '{8'h00, 8'hC0, 8'h00, 1'b0, 32'h0,    1'b1, 32'h400C, 2'd0, 1'b1, 4'b0000}, // R8 off
      '{8'hFF, 8'h7C, 8'h20, 1'b1, 32'h1000, 1'b1, 32'h4008, 2'd3, 1'b1, 4'b1001}, // R11 multi
      '{8'hFF, 8'h7C, 8'h20, 1'b1, 32'h1000, 1'b1, 32'h2000, 2'd3, 1'b1, 4'b0011}, // R11 multi
      '{8'hFF, 8'h7C, 8'h20, 1'b0, 32'h0,    1'b1, 32'h4008, 2'd3, 1'b0, 4'b0000}  // R4 read
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] mk_ctrl(input logic [7:0] en, input logic [7:0] cd, input logic [7:0] ln);
      logic [31:0] c;
      c = {24'h0, en};
      for (int n = 0; n < 4; n++) begin
         c[16 + 4*n +: 2] = cd[2*n +: 2];   // R12 condition field
         c[18 + 4*n +: 2] = ln[2*n +: 2];   // R12 length field
      end
      return c;
   endfunction

   // one request cycle; returns dbg_req seen in the next cycle
   task automatic request(input logic fv, input logic [31:0] fa, input logic dv,
                          input logic [31:0] da, input logic [1:0] ds, input logic dw,
                          output logic req_seen);
      @(negedge clk);
      fetch_valid = fv; fetch_addr = fa; data_valid = dv;
      data_addr = da; data_size = ds; data_write = dw;
      @(negedge clk);
      fetch_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0;
      req_seen = dbg_req;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        rq;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 dbg_req", {31'h0, dbg_req}, 32'h0);
      for (int a = 0; a < 6; a++) begin
         reg_read(3'(a), rd);
         check("R1 reg", rd, 32'h0);
      end

      // R2 register map
      reg_write(3'd5, 32'hFFFF_FFFF);
      reg_read(3'd5, rd);
      check("R2 ctrl 8-15 zero", rd, 32'hFFFF_00FF);
      reg_write(3'd5, 32'h0);
      reg_write(3'd4, 32'hFFFF_FFFF);
      reg_read(3'd4, rd);
      check("R2 status width", rd, 32'h0000_000F);
      reg_write(3'd4, 32'h0);
      reg_write(3'd6, 32'hDEAD_BEEF);
      reg_read(3'd6, rd);
      check("R2 offset 6", rd, 32'h0);
      reg_write(3'd0, 32'h0000_1000);
      reg_write(3'd1, 32'h0000_2003);
      reg_write(3'd2, 32'h0000_3005);
      reg_write(3'd3, 32'h0000_400C);
      reg_read(3'd2, rd);
      check("R2 slot2 addr", rd, 32'h0000_3005);
      reg_write(3'd5, mk_ctrl(8'h5A, 8'hB4, 8'h1E));
      reg_read(3'd5, rd);
      check("R12 field layout", rd, mk_ctrl(8'h5A, 8'hB4, 8'h1E));

      // table walk: R3..R8, R11
      for (int i = 0; i < NVEC; i++) begin
         reg_write(3'd5, mk_ctrl(VEC[i].en, VEC[i].cond, VEC[i].len));
         reg_write(3'd4, 32'h0);
         request(VEC[i].fv, VEC[i].fa, VEC[i].dv, VEC[i].da, VEC[i].ds, VEC[i].dw, rq);
         check($sformatf("R11 req vec %0d", i), {31'h0, rq}, {31'h0, VEC[i].exp != 4'h0});
         reg_read(3'd4, rd);
         check($sformatf("R10 status vec %0d", i), rd, {28'h0, VEC[i].exp});
         check($sformatf("R11 pulse end vec %0d", i), {31'h0, dbg_req}, 32'h0);
      end

      // R10 sticky across idle cycles, cleared by software
      reg_write(3'd5, mk_ctrl(8'h01, 8'h00, 8'h00));
      reg_write(3'd4, 32'h0);
      request(1'b1, 32'h1000, 1'b0, 32'h0, 2'd0, 1'b0, rq);
      repeat (5) @(negedge clk);
      reg_read(3'd4, rd);
      check("R10 sticky", rd, 32'h1);
      reg_write(3'd4, 32'h0);
      reg_read(3'd4, rd);
      check("R10 sw clear", rd, 32'h0);

      // R10 hit wins over concurrent clear
      reg_write(3'd4, 32'h8);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0;
      fetch_valid = 1'b1; fetch_addr = 32'h1000;
      @(negedge clk);
      reg_we = 1'b0; fetch_valid = 1'b0;
      reg_read(3'd4, rd);
      check("R10 hit over clear", rd, 32'h1);

      // R9 task switch
      reg_write(3'd5, 32'h0000_00FF);
      @(negedge clk); task_sw = 1'b1;
      @(negedge clk); task_sw = 1'b0;
      reg_read(3'd5, rd);
      check("R9 locals cleared", rd, 32'h0000_00AA);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0000_000F; task_sw = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; task_sw = 1'b0;
      reg_read(3'd5, rd);
      check("R9 write then clear", rd, 32'h0000_000A);

      // R9 task switch disables a local-only slot
      reg_write(3'd5, mk_ctrl(8'h01, 8'h00, 8'h00));
      reg_write(3'd4, 32'h0);
      @(negedge clk); task_sw = 1'b1;
      @(negedge clk); task_sw = 1'b0;
      request(1'b1, 32'h1000, 1'b0, 32'h0, 2'd0, 1'b0, rq);
      check("R9 no req after switch", {31'h0, rq}, 32'h0);
      reg_read(3'd4, rd);
      check("R9 no status after switch", rd, 32'h0);

      // R8 global survives task switch
      reg_write(3'd5, mk_ctrl(8'h02, 8'h00, 8'h00));
      @(negedge clk); task_sw = 1'b1;
      @(negedge clk); task_sw = 1'b0;
      request(1'b1, 32'h1000, 1'b0, 32'h0, 2'd0, 1'b0, rq);
      check("R8 global req", {31'h0, rq}, 32'h1);
      reg_read(3'd4, rd);
      check("R8 global status", rd, 32'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule